// File: doc/BRIEF.md
# JTAG Reset-Domain Hold Register

This block is a test-data register reached through a private 5-bit instruction. It lets a debugger or tester force any of several independent reset domains into reset and keep them there. The register has one bit for each domain. After a complete scan, a one in a bit holds that domain in reset. A zero releases it. The setting stays in force until the next complete scan changes it.

The block holds three pieces of logic:
- an instruction register with its own capture, shift and update logic and a decoder for the selecting code;
- a data shift register with a shift-length counter, so that an update after a scan of the wrong length is dropped;
- a synchronizer for each domain, clocked by that domain's clock. It applies reset at once and removes it two domain-clock edges later.

A TAP state machine outside the block supplies the one-cycle state strobes on the rising edge of TCK. The reset consumers are also outside the block.

Top module: `jtag_rst_dom_ctrl`

## Requirements
- R1: On a Capture-IR strobe, the 5-bit instruction shift register loads {prot_i, 0, 0, 0, 1} (MSB to LSB). During Shift-IR it shifts right: tdi_i enters at bit 4 and bit 0 appears on tdo_o.
- R2: sel_o is 1 exactly when the last Update-IR latched the code 5'b01100 (0x0C). No other code selects the block.
- R3: The data register is NUM_DOM bits long and shifts right: tdi_i enters the MSB and bit 0 drives tdo_o. An Update-DR after exactly NUM_DOM shifts commits the shifted value to the hold pattern. Bit i controls domain i.
- R4: A committed 1 in bit i drives dom_rst_no[i] low in the same TCK cycle as the update, without waiting for any domain clock. It stays low while the bit remains 1.
- R5: A committed 0 in bit i releases dom_rst_no[i] to 1 on the second rising edge of dom_clk_i[i] after the commit. With domain clocks of period below 5 TCK, release is complete within 10 TCK.
- R6: An Update-DR after any shift count other than NUM_DOM leaves the hold pattern and every dom_rst_no unchanged. This includes zero shifts and more than NUM_DOM shifts.
- R7: A Capture-DR while selected loads the applied hold pattern into the data register, so the scan shifts it out on tdo_o with bit 0 first.
- R8: Driving rst_ni low clears the hold pattern. After that, every domain is released and the instruction register holds 5'b11111, which leaves the block deselected.
- R9: Capture, shift and update strobes on the data path have no effect on the hold pattern while sel_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test-logic reset |
| tdi_i | input | 1 | Serial test data in |
| prot_i | input | 1 | Protection status, captured into the IR MSB |
| capture_ir_i | input | 1 | Capture-IR state strobe |
| shift_ir_i | input | 1 | Shift-IR state strobe |
| update_ir_i | input | 1 | Update-IR state strobe |
| capture_dr_i | input | 1 | Capture-DR state strobe |
| shift_dr_i | input | 1 | Shift-DR state strobe |
| update_dr_i | input | 1 | Update-DR state strobe |
| dom_clk_i | input | NUM_DOM | Clock of each reset domain |
| tdo_o | output | 1 | Serial out: IR bit 0 during Shift-IR, otherwise DR bit 0 |
| sel_o | output | 1 | Reset-control instruction is active |
| dom_rst_no | output | NUM_DOM | Active-low reset to each domain |

## Verification
The hardest case to reach from the ports is a wrong-length update that comes right after a valid one. The hold pattern is already non-zero at that point, so a dropped update can only be seen if the outputs stay exactly as they were. The stimulus therefore mixes random scan lengths of zero, NUM_DOM−1, NUM_DOM+1 and values well past the counter's saturation point with correct-length scans, all while selected. The bench compares the outputs and the Capture-DR readback against a model that accepts only full-length scans. It also checks the asynchronous assertion half a TCK after each update, before any release could have completed, and it applies a test-logic reset while domains are held.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int unsigned IR_W = 5;
  localparam logic [IR_W-1:0] IR_SEL_CODE = 5'b01100;
  localparam logic [IR_W-1:0] IR_RST_CODE = 5'b11111;
  localparam logic [IR_W-2:0] IR_CAP_LOW  = 4'b0001;
endpackage

// File: rtl/rdc_ir.sv
module rdc_ir
  import rdc_pkg::*;
(
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic tdi_i,
  input  logic prot_i,
  output logic tdo_o,
  output logic sel_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= IR_RST_CODE;
      ir_q <= IR_RST_CODE;
    end else begin
      if (capture_i)    sr_q <= {prot_i, IR_CAP_LOW};
      else if (shift_i) sr_q <= {tdi_i, sr_q[IR_W-1:1]};
      if (update_i)     ir_q <= sr_q;
    end
  end

  assign tdo_o = sr_q[0];
  assign sel_o = (ir_q == IR_SEL_CODE);

  p_ir_capture_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> tdo_o && (sr_q == {$past(prot_i), IR_CAP_LOW}));

  p_sel_decode_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    update_i |=> (sel_o == ($past(sr_q) == IR_SEL_CODE)));
endmodule

// File: rtl/rdc_dr.sv
module rdc_dr #(
  parameter int unsigned NUM_DOM = 4
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic [NUM_DOM-1:0] hold_o
);
  localparam int unsigned CNT_W = $clog2(NUM_DOM + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_DOM);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(NUM_DOM + 1);

  logic [NUM_DOM-1:0] sr_q, hold_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               len_ok;

  assign len_ok = (cnt_q == CNT_FULL);

  // shift count saturates past full length so long scans stay invalid
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sel_i) begin
      if (capture_i)                     cnt_q <= '0;
      else if (shift_i && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (sel_i) begin
      if (capture_i)    sr_q <= hold_q;
      else if (shift_i) sr_q <= {tdi_i, sr_q[NUM_DOM-1:1]};
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                           hold_q <= '0;
    else if (sel_i && update_i && len_ok)  hold_q <= sr_q;
  end

  assign tdo_o  = sr_q[0];
  assign hold_o = hold_q;

  p_full_commit_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && update_i && len_ok) |=> (hold_o == $past(sr_q)));

  p_short_ignored_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (update_i && !len_ok) |=> $stable(hold_o));

  p_readback_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && capture_i) |=> (sr_q == $past(hold_o)));

  p_unsel_ignored_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_i |=> $stable(hold_o));
endmodule

// File: rtl/rdc_sync.sv
module rdc_sync #(
  parameter int unsigned NUM_DOM = 4,
  parameter int unsigned STAGES  = 2
) (
  input  logic [NUM_DOM-1:0] dom_clk_i,
  input  logic [NUM_DOM-1:0] hold_i,
  output logic [NUM_DOM-1:0] dom_rst_no
);
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    logic [STAGES-1:0] chain_q;

    // assertion is asynchronous, release walks the chain in the domain clock
    always_ff @(posedge dom_clk_i[g] or posedge hold_i[g]) begin
      if (hold_i[g]) chain_q <= '0;
      else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign dom_rst_no[g] = chain_q[STAGES-1];

    p_release_order_r5: assert property (@(posedge dom_clk_i[g]) disable iff (hold_i[g])
      $rose(dom_rst_no[g]) |-> $past(chain_q[0]));
  end
endmodule

// File: rtl/jtag_rst_dom_ctrl.sv
module jtag_rst_dom_ctrl #(
  parameter int unsigned NUM_DOM = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tdi_i,
  input  logic               prot_i,
  input  logic               capture_ir_i,
  input  logic               shift_ir_i,
  input  logic               update_ir_i,
  input  logic               capture_dr_i,
  input  logic               shift_dr_i,
  input  logic               update_dr_i,
  input  logic [NUM_DOM-1:0] dom_clk_i,
  output logic               tdo_o,
  output logic               sel_o,
  output logic [NUM_DOM-1:0] dom_rst_no
);
  logic               ir_tdo, dr_tdo, sel;
  logic [NUM_DOM-1:0] hold;

  rdc_ir u_ir (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_ir_i),
    .shift_i   (shift_ir_i),
    .update_i  (update_ir_i),
    .tdi_i     (tdi_i),
    .prot_i    (prot_i),
    .tdo_o     (ir_tdo),
    .sel_o     (sel)
  );

  rdc_dr #(.NUM_DOM(NUM_DOM)) u_dr (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .capture_i (capture_dr_i),
    .shift_i   (shift_dr_i),
    .update_i  (update_dr_i),
    .tdi_i     (tdi_i),
    .tdo_o     (dr_tdo),
    .hold_o    (hold)
  );

  rdc_sync #(.NUM_DOM(NUM_DOM), .STAGES(SYNC_STAGES)) u_sync (
    .dom_clk_i  (dom_clk_i),
    .hold_i     (hold),
    .dom_rst_no (dom_rst_no)
  );

  assign sel_o = sel;
  assign tdo_o = shift_ir_i ? ir_tdo : dr_tdo;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_chk
    p_hold_asserts_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
      (hold[g] && $past(hold[g])) |-> !dom_rst_no[g]);
  end

  p_trst_clears_r8: assert property (@(posedge tck_i)
    !rst_ni |-> (hold == '0) && !sel_o);
endmodule

// File: tb/jtag_rst_dom_ctrl_tb.sv
module jtag_rst_dom_ctrl_tb;
  localparam int N = 4;
  localparam time TCK_PERIOD = 10;

  logic tck = 0, rst_n = 0, tdi = 0, prot = 0;
  logic cap_ir = 0, sh_ir = 0, up_ir = 0, cap_dr = 0, sh_dr = 0, up_dr = 0;
  logic [7:0] base = '0;
  logic [N-1:0] dom_clk;
  logic tdo, sel;
  logic [N-1:0] dom_rst_n;

  int total = 0, bad = 0;
  logic [N-1:0] exp_hold = '0;
  logic sel_exp = 0;

  always #(TCK_PERIOD/2) tck = ~tck;
  always #1 base = base + 1'b1;
  assign dom_clk = base[N:1];

  jtag_rst_dom_ctrl #(.NUM_DOM(N)) u_dut (
    .tck_i(tck), .rst_ni(rst_n), .tdi_i(tdi), .prot_i(prot),
    .capture_ir_i(cap_ir), .shift_ir_i(sh_ir), .update_ir_i(up_ir),
    .capture_dr_i(cap_dr), .shift_dr_i(sh_dr), .update_dr_i(up_dr),
    .dom_clk_i(dom_clk), .tdo_o(tdo), .sel_o(sel), .dom_rst_no(dom_rst_n)
  );

  function automatic logic [4:0] ir_cap_val(input logic p);
    return {p, 4'b0001};
  endfunction

  function automatic logic [N-1:0] rst_expect(input logic [N-1:0] h);
    return ~h;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck); @(negedge tck);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic ir_scan(input logic [4:0] code);
    logic [4:0] cap;
    prot = 1'($urandom % 2);
    cap_ir = 1; tick(); cap_ir = 0;
    sh_ir = 1;
    for (int k = 0; k < 5; k++) begin
      tdi = code[k]; #1; cap[k] = tdo; tick();
    end
    sh_ir = 0; tdi = 0;
    up_ir = 1; tick(); up_ir = 0;
    chk(cap == ir_cap_val(prot), "R1 ir capture", 32'(cap), 32'(ir_cap_val(prot)));
    sel_exp = (code == 5'b01100);
    chk(sel == sel_exp, "R2 select decode", 32'(sel), 32'(sel_exp));
  endtask

  task automatic dr_scan(input logic [N-1:0] val, input int len);
    logic [N-1:0] rb, prev;
    prev = exp_hold;
    rb = '0;
    cap_dr = 1; tick(); cap_dr = 0;
    sh_dr = 1;
    for (int k = 0; k < len; k++) begin
      tdi = (k < N) ? val[k] : 1'($urandom % 2);
      #1;
      if (k < N) rb[k] = tdo;
      tick();
    end
    sh_dr = 0; tdi = 0;
    up_dr = 1; tick(); up_dr = 0;
    if (sel_exp && len >= N)
      chk(rb == prev, "R7 readback", 32'(rb), 32'(prev));
    if (sel_exp && len == N) exp_hold = val;
    // set bits must already be in reset half a TCK after the update edge
    for (int i = 0; i < N; i++)
      if (exp_hold[i])
        chk(dom_rst_n[i] == 1'b0, "R4 async assert", 32'(dom_rst_n), 32'(rst_expect(exp_hold)));
    wait_ticks(10);
    if (!sel_exp)
      chk(dom_rst_n == rst_expect(exp_hold), "R9 unselected no effect", 32'(dom_rst_n), 32'(rst_expect(exp_hold)));
    else if (len != N)
      chk(dom_rst_n == rst_expect(exp_hold), "R6 wrong length ignored", 32'(dom_rst_n), 32'(rst_expect(exp_hold)));
    else
      chk(dom_rst_n == rst_expect(exp_hold), "R3 R5 commit and release", 32'(dom_rst_n), 32'(rst_expect(exp_hold)));
  endtask

  initial begin
    #(TCK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    wait_ticks(3);
    rst_n = 1;
    wait_ticks(10);
    chk(dom_rst_n == '1, "R8 reset state released", 32'(dom_rst_n), 32'hF);
    chk(sel == 1'b0, "R8 reset state deselected", 32'(sel), 32'h0);

    // unselected scans leave domains alone
    dr_scan(4'hF, N);
    ir_scan(5'b01101);
    dr_scan(4'hA, N);

    ir_scan(5'b01100);
    dr_scan(4'b1010, N);
    dr_scan(4'b0110, N);
    dr_scan(4'b1111, 0);
    dr_scan(4'b0000, N - 1);
    dr_scan(4'b0000, N + 1);
    dr_scan(4'b0001, N + 7);
    dr_scan(4'b0000, N);
    dr_scan(4'b1111, N);

    for (int it = 0; it < 60; it++) begin
      int pick, len;
      logic [N-1:0] v;
      pick = int'($urandom % 10);
      v = N'($urandom);
      if (pick == 0) ir_scan(5'($urandom));
      else if (pick == 1) ir_scan(5'b01100);
      case ($urandom % 5)
        0: len = N - 1;
        1: len = N + 1;
        2: len = int'($urandom % (N + 5));
        default: len = N;
      endcase
      dr_scan(v, len);
    end

    // test-logic reset while domains are held
    ir_scan(5'b01100);
    dr_scan(4'b1101, N);
    rst_n = 0; tick(); tick(); rst_n = 1;
    exp_hold = '0; sel_exp = 0;
    wait_ticks(10);
    chk(dom_rst_n == '1, "R8 trst releases all", 32'(dom_rst_n), 32'hF);
    chk(sel == 1'b0, "R8 trst deselects", 32'(sel), 32'h0);
    ir_scan(5'b01100);
    dr_scan(4'b0011, N);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule